// File: doc/BRIEF.md
# Thread Slot Lock and Queue Manager

This block keeps a fixed pool of lightweight thread slots and a small set of locks in on-chip registers. A slot holds exactly two things: a link to another slot and the address of the routine it runs or will run. A single shared link table threads every slot into one list at a time. The lists are the idle pool, the ready-to-run FIFO, or the wait FIFO of one lock. A slot that has been allocated or dequeued is held by its caller and sits on no list.

A controller issues one command at a time. The commands are acquire, release, allocate, schedule and dequeue. The block answers with a status code and a slot index. A blocked acquire puts the caller at the tail of the lock's wait FIFO. A release by the owner passes ownership straight to the oldest waiter and appends that waiter to the ready FIFO. Scheduling takes an idle slot, stores a routine address in it and queues it as ready. The block only rewrites links and owner fields. Dispatch to processors, parameters, stacks and execution are handled elsewhere.

Top module: `thread_lock_queue`

## Requirements
- R1: After reset, cmd_ready is 1, done is 0, every lock is free and the ready FIFO is empty. All slots are idle, chained in index order, so successive allocates return slots 0, 1, 2 and so on.
- R2: Acquire (op 0) on a free lock makes the caller (cmd_slot) the owner and answers grant (status 1) with resp_slot equal to the caller.
- R3: Acquire on an owned lock appends the caller to the tail of that lock's wait FIFO and answers wait (status 2) with resp_slot equal to the caller.
- R4: Release (op 1) by the owner while threads wait makes the oldest waiter the owner and appends it to the tail of the ready FIFO. It answers handoff (status 3) with resp_slot equal to that waiter.
- R5: Release by the owner with no waiters frees the lock and answers ok (status 0) with resp_slot null (all ones). A later acquire is then granted.
- R6: Release by any slot other than the owner answers error (status 5) and leaves the owner and the wait FIFO unchanged.
- R7: Schedule (op 3) pops the head of the idle list and stores cmd_addr in it. It appends that slot to the ready FIFO and answers ok with that slot in resp_slot and cmd_addr in resp_addr.
- R8: Dequeue (op 4) pops the head of the ready FIFO. It answers ok with that slot in resp_slot and its stored routine address in resp_addr, and slots leave in the order they entered.
- R9: Allocate (op 2) pops the head of the idle list and answers ok with that slot in resp_slot.
- R10: Allocate or schedule with an empty idle list, and dequeue with an empty ready FIFO, answer empty (status 4) with resp_slot null and change no list.
- R11: A command is accepted at a clock edge where cmd_valid and cmd_ready are both high. cmd_ready is low in the next cycle, and done is a one-cycle pulse in the cycle after that. resp_addr is 0 except where R7 or R8 says otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 3 | Operation code (0 acquire, 1 release, 2 allocate, 3 schedule, 4 dequeue) |
| cmd_lock | input | LOCK_W | Lock index for acquire and release |
| cmd_slot | input | SLOT_W | Calling slot for acquire and release |
| cmd_addr | input | ADDR_W | Routine address for schedule |
| done | output | 1 | Response valid pulse |
| status | output | 3 | 0 ok, 1 grant, 2 wait, 3 handoff, 4 empty, 5 error |
| resp_slot | output | SLOT_W | Slot index returned, all ones for null |
| resp_addr | output | ADDR_W | Routine address returned |

## Verification
The assertions rely on the caller's discipline. An acquire names a held slot that is below the slot count, on no list and not already the owner of that lock. The controller also never raises cmd_valid unless it wants the command taken. The bench keeps a reference model of every slot's state and draws random operations, but it only acquires with slots that the model marks as held and not owning that lock. Releases, by contrast, use deliberately wrong callers one time in four. Directed sequences at reset cover the idle chain order, empty lists, the wait FIFO order and the error path.

// File: rtl/thread_lock_queue.sv
module thread_lock_queue #(
  parameter int NUM_SLOTS = 8,
  parameter int NUM_LOCKS = 4,
  parameter int ADDR_W    = 16,
  localparam int SLOT_W   = $clog2(NUM_SLOTS + 1),
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int LOCK_W   = $clog2(NUM_LOCKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [LOCK_W-1:0] cmd_lock,
  input  logic [SLOT_W-1:0] cmd_slot,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              done,
  output logic [2:0]        status,
  output logic [SLOT_W-1:0] resp_slot,
  output logic [ADDR_W-1:0] resp_addr
);

  localparam logic [SLOT_W-1:0] NIL = '1;

  localparam logic [2:0] OP_ACQ   = 3'd0;
  localparam logic [2:0] OP_REL   = 3'd1;
  localparam logic [2:0] OP_ALLOC = 3'd2;
  localparam logic [2:0] OP_SCHED = 3'd3;
  localparam logic [2:0] OP_DEQ   = 3'd4;

  localparam logic [2:0] ST_OK      = 3'd0;
  localparam logic [2:0] ST_GRANT   = 3'd1;
  localparam logic [2:0] ST_WAIT    = 3'd2;
  localparam logic [2:0] ST_HANDOFF = 3'd3;
  localparam logic [2:0] ST_EMPTY   = 3'd4;
  localparam logic [2:0] ST_ERR     = 3'd5;

  logic              busy_q;
  logic [2:0]        op_q;
  logic [LOCK_W-1:0] lock_q;
  logic [SLOT_W-1:0] slot_q;
  logic [ADDR_W-1:0] addr_in_q;

  logic [SLOT_W-1:0] link_q [NUM_SLOTS];
  logic [ADDR_W-1:0] rtn_q  [NUM_SLOTS];
  logic [SLOT_W-1:0] idle_hd, idle_tl, act_hd, act_tl;
  logic [SLOT_W-1:0] own_q [NUM_LOCKS];
  logic [SLOT_W-1:0] wh_q  [NUM_LOCKS];
  logic [SLOT_W-1:0] wt_q  [NUM_LOCKS];

  logic              done_q;
  logic [2:0]        status_q;
  logic [SLOT_W-1:0] rslot_q;
  logic [ADDR_W-1:0] raddr_q;

  logic [SLOT_W-1:0] own, wh, wt;
  logic [IDX_W-1:0]  sc_i, wh_i, wt_i, ih_i, at_i, ah_i;

  assign own  = own_q[lock_q];
  assign wh   = wh_q[lock_q];
  assign wt   = wt_q[lock_q];
  assign sc_i = slot_q[IDX_W-1:0];
  assign wh_i = wh[IDX_W-1:0];
  assign wt_i = wt[IDX_W-1:0];
  assign ih_i = idle_hd[IDX_W-1:0];
  assign ah_i = act_hd[IDX_W-1:0];
  assign at_i = act_tl[IDX_W-1:0];

  assign cmd_ready = !busy_q;
  assign done      = done_q;
  assign status    = status_q;
  assign resp_slot = rslot_q;
  assign resp_addr = raddr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      op_q      <= '0;
      lock_q    <= '0;
      slot_q    <= '0;
      addr_in_q <= '0;
      done_q    <= 1'b0;
      status_q  <= ST_OK;
      rslot_q   <= NIL;
      raddr_q   <= '0;
      idle_hd   <= '0;
      idle_tl   <= SLOT_W'(NUM_SLOTS - 1);
      act_hd    <= NIL;
      act_tl    <= NIL;
      for (int i = 0; i < NUM_SLOTS; i++) begin
        link_q[i] <= (i == NUM_SLOTS - 1) ? NIL : SLOT_W'(i + 1);
        rtn_q[i]  <= '0;
      end
      for (int l = 0; l < NUM_LOCKS; l++) begin
        own_q[l] <= NIL;
        wh_q[l]  <= NIL;
        wt_q[l]  <= NIL;
      end
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (cmd_valid) begin
          busy_q    <= 1'b1;
          op_q      <= cmd_op;
          lock_q    <= cmd_lock;
          slot_q    <= cmd_slot;
          addr_in_q <= cmd_addr;
        end
      end else begin
        busy_q  <= 1'b0;
        done_q  <= 1'b1;
        rslot_q <= NIL;
        raddr_q <= '0;
        case (op_q)
          OP_ACQ: begin
            rslot_q <= slot_q;
            if (own == NIL) begin
              own_q[lock_q] <= slot_q;
              status_q      <= ST_GRANT;
            end else begin
              link_q[sc_i] <= NIL;
              if (wh == NIL) wh_q[lock_q] <= slot_q;
              else           link_q[wt_i] <= slot_q;
              wt_q[lock_q] <= slot_q;
              status_q     <= ST_WAIT;
            end
          end
          OP_REL: begin
            if (own != slot_q) begin
              status_q <= ST_ERR;
            end else if (wh == NIL) begin
              own_q[lock_q] <= NIL;
              status_q      <= ST_OK;
            end else begin
              own_q[lock_q] <= wh;
              wh_q[lock_q]  <= link_q[wh_i];
              if (wh == wt) wt_q[lock_q] <= NIL;
              link_q[wh_i] <= NIL;
              if (act_hd == NIL) act_hd <= wh;
              else               link_q[at_i] <= wh;
              act_tl   <= wh;
              rslot_q  <= wh;
              status_q <= ST_HANDOFF;
            end
          end
          OP_ALLOC: begin
            if (idle_hd == NIL) begin
              status_q <= ST_EMPTY;
            end else begin
              idle_hd <= link_q[ih_i];
              if (idle_hd == idle_tl) idle_tl <= NIL;
              link_q[ih_i] <= NIL;
              rslot_q  <= idle_hd;
              status_q <= ST_OK;
            end
          end
          OP_SCHED: begin
            if (idle_hd == NIL) begin
              status_q <= ST_EMPTY;
            end else begin
              idle_hd <= link_q[ih_i];
              if (idle_hd == idle_tl) idle_tl <= NIL;
              rtn_q[ih_i]  <= addr_in_q;
              link_q[ih_i] <= NIL;
              if (act_hd == NIL) act_hd <= idle_hd;
              else               link_q[at_i] <= idle_hd;
              act_tl   <= idle_hd;
              rslot_q  <= idle_hd;
              raddr_q  <= addr_in_q;
              status_q <= ST_OK;
            end
          end
          OP_DEQ: begin
            if (act_hd == NIL) begin
              status_q <= ST_EMPTY;
            end else begin
              act_hd <= link_q[ah_i];
              if (act_hd == act_tl) act_tl <= NIL;
              link_q[ah_i] <= NIL;
              rslot_q  <= act_hd;
              raddr_q  <= rtn_q[ah_i];
              status_q <= ST_OK;
            end
          end
          default: status_q <= ST_ERR;
        endcase
      end
    end
  end

endmodule

// File: rtl/thread_lock_queue_chk.sv
module thread_lock_queue_chk #(
  parameter int SLOT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_op,
  input logic [SLOT_W-1:0] cmd_slot,
  input logic              done,
  input logic [2:0]        status,
  input logic [SLOT_W-1:0] resp_slot
);

  logic accept;
  assign accept = cmd_valid && cmd_ready;

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !cmd_ready); // R11
  AST_DONE_TWO_LATER: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ##2 done); // R11
  AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(accept, 2)); // R11
  AST_GRANT_TO_CALLER: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 3'd1) |-> (resp_slot == $past(cmd_slot, 2) && $past(cmd_op, 2) == 3'd0)); // R2
  AST_WAIT_IS_CALLER: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 3'd2) |-> (resp_slot == $past(cmd_slot, 2) && $past(cmd_op, 2) == 3'd0)); // R3
  AST_HANDOFF_FROM_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 3'd3) |-> ($past(cmd_op, 2) == 3'd1 && resp_slot != $past(cmd_slot, 2))); // R4
  AST_EMPTY_NULL_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 3'd4) |-> resp_slot == '1); // R10

endmodule

bind thread_lock_queue thread_lock_queue_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_slot(cmd_slot), .done(done), .status(status),
  .resp_slot(resp_slot)
);

// File: tb/test_thread_lock_queue.sv
module test_thread_lock_queue;
  localparam int CLK_PERIOD = 10;
  localparam int NSLOT = 8;
  localparam int NLOCK = 4;
  localparam int NIL = 15;
  localparam int HELD = 1, WAITING = 2, ACTIVE = 3, IDLE = 0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [1:0] cmd_lock = '0;
  logic [3:0] cmd_slot = '0;
  logic [15:0] cmd_addr = '0;
  logic done;
  logic [2:0] status;
  logic [3:0] resp_slot;
  logic [15:0] resp_addr;

  int total = 0;
  int fails = 0;

  int idle_q[$];
  int act_q[$];
  int wq[NLOCK][$];
  int owner[NLOCK];
  int addr_m[NSLOT];
  int st[NSLOT];

  always #(CLK_PERIOD/2) clk = ~clk;

  thread_lock_queue i_thread_lock_queue (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_lock(cmd_lock), .cmd_slot(cmd_slot), .cmd_addr(cmd_addr),
    .done(done), .status(status), .resp_slot(resp_slot), .resp_addr(resp_addr)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    idle_q.delete();
    act_q.delete();
    for (int i = 0; i < NSLOT; i++) begin idle_q.push_back(i); addr_m[i] = 0; st[i] = IDLE; end
    for (int l = 0; l < NLOCK; l++) begin owner[l] = NIL; wq[l].delete(); end
  endtask

  task automatic model(input int op, input int lk, input int sl, input int ad,
                       output int es, output int eslot, output int eaddr);
    int w;
    es = 0; eslot = NIL; eaddr = 0;
    case (op)
      0: begin
        eslot = sl;
        if (owner[lk] == NIL) begin owner[lk] = sl; es = 1; end
        else begin wq[lk].push_back(sl); st[sl] = WAITING; es = 2; end
      end
      1: begin
        if (owner[lk] != sl) es = 5;
        else if (wq[lk].size() == 0) begin owner[lk] = NIL; es = 0; end
        else begin
          w = wq[lk].pop_front();
          owner[lk] = w; st[w] = ACTIVE; act_q.push_back(w);
          es = 3; eslot = w;
        end
      end
      2: begin
        if (idle_q.size() == 0) es = 4;
        else begin w = idle_q.pop_front(); st[w] = HELD; eslot = w; end
      end
      3: begin
        if (idle_q.size() == 0) es = 4;
        else begin
          w = idle_q.pop_front(); st[w] = ACTIVE; addr_m[w] = ad;
          act_q.push_back(w); eslot = w; eaddr = ad;
        end
      end
      4: begin
        if (act_q.size() == 0) es = 4;
        else begin w = act_q.pop_front(); st[w] = HELD; eslot = w; eaddr = addr_m[w]; end
      end
      default: es = 5;
    endcase
  endtask

  task automatic run_cmd(input int op, input int lk, input int sl, input int ad, input string req);
    int es, eslot, eaddr;
    model(op, lk, sl, ad, es, eslot, eaddr);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op = op[2:0]; cmd_lock = lk[1:0]; cmd_slot = sl[3:0]; cmd_addr = ad[15:0];
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R11", "ready while busy", int'(cmd_ready), 0);
    @(negedge clk);
    chk("R11", "done pulse", int'(done), 1);
    chk(req, "status", int'(status), es);
    chk(req, "resp_slot", int'(resp_slot), eslot);
    chk(req, "resp_addr", int'(resp_addr), eaddr);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ready after reset", int'(cmd_ready), 1);
    chk("R1", "done after reset", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R1 R9: idle chain in index order
    for (int i = 0; i < NSLOT; i++) run_cmd(2, 0, 0, 0, "R1 R9");
    run_cmd(2, 0, 0, 0, "R10");
    run_cmd(3, 0, 0, 16'h1234, "R10");
    run_cmd(4, 0, 0, 0, "R10");
    run_cmd(0, 0, 0, 0, "R2");
    run_cmd(0, 0, 1, 0, "R3");
    run_cmd(0, 0, 2, 0, "R3");
    run_cmd(1, 0, 3, 0, "R6");
    run_cmd(1, 0, 0, 0, "R4");
    run_cmd(1, 0, 0, 0, "R6");
    run_cmd(4, 0, 0, 0, "R4 R8");
    run_cmd(1, 0, 1, 0, "R4");
    run_cmd(1, 0, 2, 0, "R5");
    run_cmd(0, 0, 5, 0, "R5 R2");
    do_reset();
    run_cmd(3, 0, 0, 16'hA5A5, "R7");
    run_cmd(3, 0, 0, 16'h0F0F, "R7");
    run_cmd(4, 0, 0, 0, "R8");
    run_cmd(4, 0, 0, 0, "R8");
    run_cmd(4, 0, 0, 0, "R10");

    for (int n = 0; n < 800; n++) begin
      int r, lk, s;
      if (n % 200 == 0) do_reset();
      r = int'($urandom % 6);
      lk = int'($urandom % NLOCK);
      s = int'($urandom % NSLOT);
      case (r)
        0: run_cmd(2, 0, 0, 0, "R9");
        1: run_cmd(3, 0, 0, int'($urandom % 65536), "R7");
        2: run_cmd(4, 0, 0, 0, "R8");
        3, 4: begin
          if (st[s] == HELD && owner[lk] != s) run_cmd(0, lk, s, 0, "R2 R3");
          else run_cmd(4, 0, 0, 0, "R8");
        end
        default: begin
          if (owner[lk] != NIL && ($urandom % 4) != 0) run_cmd(1, lk, owner[lk], 0, "R4 R5");
          else run_cmd(1, lk, s, 0, "R6");
        end
      endcase
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule